// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block carries out the hardware part of exception handling for a small 32-bit core. Seven request inputs arrive from the rest of the core: hard reset request, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software call. In a single clock edge the controller picks the winning request and copies the live status word into the saved-status register of the target mode. It also writes the return address into that mode's link register, rewrites the mode, mask and instruction-state bits, and emits a one-cycle PC load carrying the fixed vector address.

The core returns from a handler with a return strobe and the address to resume at. The controller copies the current mode's saved status back into the live status word and loads the PC in that same edge. Software writes to the status word always update the condition flags. They update the control byte (mode, masks, state bit) only from a privileged mode. The handler reads the banked saved status and link of its current mode from two output ports.

The controller is a two-state machine. `ST_RUN` is the ordinary state. `ST_ENTERED` lasts for the cycle that follows any accepted exception, and `exc_taken` is driven from it. The transition `ST_RUN`/`ST_ENTERED` -> `ST_ENTERED` happens on every edge that accepts an exception. The transition back to `ST_RUN` happens on every edge that accepts none.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status word is 0x000000D3 (supervisor mode, both interrupt masks set, 32-bit state), `pc_load` and `exc_taken` are 0, and every banked register reads 0.
- R2: When several requests are eligible in the same cycle, exactly one is taken, in this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software call. A fast interrupt can preempt a normal-interrupt handler.
- R3: The cycle after an entry, `pc_load` is 1 and `pc_target` equals 4 × the exception code. The codes are 0 reset, 1 undefined, 2 software call, 3 prefetch abort, 4 data abort, 6 normal interrupt, 7 fast interrupt.
- R4: Entry sets status bits 4:0 to the target mode. Reset and software call go to 0x13, undefined to 0x1B, both aborts to 0x17, normal interrupt to 0x12 and fast interrupt to 0x11.
- R5: Every entry sets bit 7, the normal-interrupt mask. Bit 6, the fast-interrupt mask, is set only by reset and fast-interrupt entries and is otherwise left unchanged.
- R6: Entry copies the pre-entry status word into the target mode's saved-status register. `saved_status` and `link_reg` show the current mode's bank, and read 0 in modes that have no bank (user 0x10, system 0x1F).
- R7: Entry writes `cur_pc + 4` into the target mode's link register, or `cur_pc + 2` when status bit 5 (compact 16-bit state) is set.
- R8: Entry clears status bit 5.
- R9: `req_norm` is ignored while bit 7 is set, and `req_fast` is ignored while bit 6 is set.
- R10: When a return strobe arrives in a banked mode with no exception in that cycle, the status word is loaded from that mode's saved status, and the next cycle shows `pc_load`=1 with `pc_target`=`ret_addr`. A return in user or system mode, or in a cycle with an accepted exception, has no effect.
- R11: A software write with no exception or return in that cycle always copies `sw_data[31:28]` into the flags. It copies `sw_data[7:0]` into the control byte only when the current mode is not user (0x10).
- R12: `exc_taken` is 1 only in the cycle after an accepted entry. `exc_code` holds the code of the most recent entry (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_dabort | input | 1 | Data abort request |
| req_fast | input | 1 | Fast interrupt request (level) |
| req_norm | input | 1 | Normal interrupt request (level) |
| req_pabort | input | 1 | Prefetch abort request |
| req_undef | input | 1 | Undefined instruction request |
| req_call | input | 1 | Software call request |
| cur_pc | input | 32 | Address of the current instruction |
| ret_strobe | input | 1 | Exception return strobe |
| ret_addr | input | 32 | Address to resume at on return |
| sw_wr | input | 1 | Software status write strobe |
| sw_data | input | 32 | Software status write value |
| status | output | 32 | Live status word |
| saved_status | output | 32 | Saved status of the current mode's bank |
| link_reg | output | 32 | Link register of the current mode's bank |
| pc_load | output | 1 | One-cycle PC load strobe |
| pc_target | output | 32 | Vector or return address for the PC load |
| exc_taken | output | 1 | One-cycle entry pulse |
| exc_code | output | 3 | Code of the most recent entry |

## Verification
The hardest situation to reach is a nested preemption followed by a clean unwind. A normal-interrupt handler has to be running with the fast mask clear when a fast interrupt arrives. Each return must then restore the right bank in turn: fast to normal, normal to supervisor, supervisor to user. The stimulus builds this chain on purpose. It clears the masks with a privileged software write, holds the normal request so that it is taken only after a return unmasks it, and then raises the fast request inside the normal handler. A reference model in the bench is compared against every output on every clock. Directed sequences cover arbitration with all requests raised at once and the collisions of an exception with a return or a software write. A long random phase follows them.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int CODE_W    = 3;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int NUM_PRI   = 7;
    localparam int NUM_BANKS = 5;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    localparam int BIT_I = 7;
    localparam int BIT_F = 6;
    localparam int BIT_T = 5;

    localparam logic [4:0] MODE_USR = 5'h10;
    localparam logic [4:0] MODE_FIQ = 5'h11;
    localparam logic [4:0] MODE_IRQ = 5'h12;
    localparam logic [4:0] MODE_SVC = 5'h13;
    localparam logic [4:0] MODE_ABT = 5'h17;
    localparam logic [4:0] MODE_UND = 5'h1B;

    // Code value times four is the vector offset.
    typedef enum logic [CODE_W-1:0] {
        EXC_RESET = 3'd0,
        EXC_UNDEF = 3'd1,
        EXC_CALL  = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_RSVD  = 3'd5,
        EXC_IRQ   = 3'd6,
        EXC_FIQ   = 3'd7
    } exc_code_e;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_ENTERED = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] idx;
    } bank_sel_t;

    // Rank 0 is the highest priority.
    function automatic exc_code_e pri_code(input int rank);
        case (rank)
            0:       return EXC_RESET;
            1:       return EXC_DABT;
            2:       return EXC_FIQ;
            3:       return EXC_IRQ;
            4:       return EXC_PABT;
            5:       return EXC_UNDEF;
            default: return EXC_CALL;
        endcase
    endfunction

    function automatic logic [4:0] mode_of(input exc_code_e c);
        case (c)
            EXC_FIQ:            return MODE_FIQ;
            EXC_IRQ:            return MODE_IRQ;
            EXC_UNDEF:          return MODE_UND;
            EXC_PABT, EXC_DABT: return MODE_ABT;
            default:            return MODE_SVC;
        endcase
    endfunction

    function automatic bank_sel_t bank_of(input logic [4:0] m);
        bank_sel_t s;
        s.hit = 1'b1;
        case (m)
            MODE_FIQ: s.idx = BANK_W'(0);
            MODE_IRQ: s.idx = BANK_W'(1);
            MODE_SVC: s.idx = BANK_W'(2);
            MODE_ABT: s.idx = BANK_W'(3);
            MODE_UND: s.idx = BANK_W'(4);
            default: begin
                s.hit = 1'b0;
                s.idx = '0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int NREQ = NUM_CODES
) (
    input  logic [NREQ-1:0] req_vec,
    output logic            grant_valid,
    output exc_code_e       grant_code,
    output logic [NREQ-1:0] grant_vec
);

    always_comb begin
        grant_valid = 1'b0;
        grant_code  = EXC_RESET;
        for (int r = NUM_PRI - 1; r >= 0; r--) begin
            if (req_vec[pri_code(r)]) begin
                grant_valid = 1'b1;
                grant_code  = pri_code(r);
            end
        end
        grant_vec = grant_valid ? (NREQ'(1) << grant_code) : '0;
    end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NBANK = NUM_BANKS,
    localparam int IW   = $clog2(NBANK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_status,
    input  logic [XLEN-1:0] wr_link,
    input  logic [IW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_status,
    output logic [XLEN-1:0] rd_link
);

    logic [XLEN-1:0] st_q [NBANK];
    logic [XLEN-1:0] lk_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[b] <= '0;
                lk_q[b] <= '0;
            end else if (wr_en && wr_idx == IW'(b)) begin
                st_q[b] <= wr_status;
                lk_q[b] <= wr_link;
            end
        end
    end

    always_comb begin
        rd_status = '0;
        rd_link   = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (rd_idx == IW'(b)) begin
                rd_status = st_q[b];
                rd_link   = lk_q[b];
            end
        end
    end

    // R6
    bank_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NBANK));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_dabort,
    input  logic              req_fast,
    input  logic              req_norm,
    input  logic              req_pabort,
    input  logic              req_undef,
    input  logic              req_call,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              ret_strobe,
    input  logic [XLEN-1:0]   ret_addr,
    input  logic              sw_wr,
    input  logic [XLEN-1:0]   sw_data,
    output logic [XLEN-1:0]   status,
    output logic [XLEN-1:0]   saved_status,
    output logic [XLEN-1:0]   link_reg,
    output logic              pc_load,
    output logic [XLEN-1:0]   pc_target,
    output logic              exc_taken,
    output logic [CODE_W-1:0] exc_code
);

    localparam logic [XLEN-1:0] RESET_STATUS =
        XLEN'({1'b1, 1'b1, 1'b0, MODE_SVC});

    ctl_state_e state_q, state_d;
    logic [XLEN-1:0] status_q, status_d;
    logic [XLEN-1:0] entry_status, link_val, vec_addr;
    logic [XLEN-1:0] bank_rd_status, bank_rd_link;
    logic [NUM_CODES-1:0] req_vec, grant_vec;
    logic exc_go, ret_ok, priv;
    exc_code_e take_code, code_q;
    logic [4:0] tgt_mode;
    bank_sel_t cur_bank, tgt_bank;

    assign priv     = (status_q[4:0] != MODE_USR);
    assign cur_bank = bank_of(status_q[4:0]);

    // Interrupt lines only count while their mask bit is clear.
    always_comb begin
        req_vec            = '0;
        req_vec[EXC_RESET] = req_reset;
        req_vec[EXC_UNDEF] = req_undef;
        req_vec[EXC_CALL]  = req_call;
        req_vec[EXC_PABT]  = req_pabort;
        req_vec[EXC_DABT]  = req_dabort;
        req_vec[EXC_IRQ]   = req_norm & ~status_q[BIT_I];
        req_vec[EXC_FIQ]   = req_fast & ~status_q[BIT_F];
    end

    exc_arbiter #(.NREQ(NUM_CODES)) u_arb (
        .req_vec     (req_vec),
        .grant_valid (exc_go),
        .grant_code  (take_code),
        .grant_vec   (grant_vec)
    );

    assign tgt_mode = mode_of(take_code);
    assign tgt_bank = bank_of(tgt_mode);
    assign link_val = cur_pc + (status_q[BIT_T] ? XLEN'(2) : XLEN'(4));
    assign vec_addr = XLEN'({take_code, 2'b00});
    assign ret_ok   = ret_strobe & cur_bank.hit & ~exc_go;

    always_comb begin
        entry_status        = status_q;
        entry_status[4:0]   = tgt_mode;
        entry_status[BIT_I] = 1'b1;
        entry_status[BIT_T] = 1'b0;
        if (take_code == EXC_FIQ || take_code == EXC_RESET)
            entry_status[BIT_F] = 1'b1;
    end

    exc_bank #(.XLEN(XLEN), .NBANK(NUM_BANKS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (exc_go),
        .wr_idx    (tgt_bank.idx),
        .wr_status (status_q),
        .wr_link   (link_val),
        .rd_idx    (cur_bank.idx),
        .rd_status (bank_rd_status),
        .rd_link   (bank_rd_link)
    );

    // Next status: entry over return over software write.
    always_comb begin
        status_d = status_q;
        if (exc_go) begin
            status_d = entry_status;
        end else if (ret_ok) begin
            status_d = bank_rd_status;
        end else if (sw_wr) begin
            status_d[XLEN-1:XLEN-4] = sw_data[XLEN-1:XLEN-4];
            if (priv) status_d[7:0] = sw_data[7:0];
        end
    end

    always_comb begin
        state_d = exc_go ? ST_ENTERED : ST_RUN;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q  <= RESET_STATUS;
            pc_load   <= 1'b0;
            pc_target <= '0;
            code_q    <= EXC_RESET;
        end else begin
            status_q <= status_d;
            pc_load  <= exc_go | ret_ok;
            if (exc_go) begin
                pc_target <= vec_addr;
                code_q    <= take_code;
            end else if (ret_ok) begin
                pc_target <= ret_addr;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        exc_taken = 1'b0;
        unique case (state_q)
            ST_RUN:     exc_taken = 1'b0;
            ST_ENTERED: exc_taken = 1'b1;
        endcase
    end

    assign status       = status_q;
    assign exc_code     = code_q;
    assign saved_status = cur_bank.hit ? bank_rd_status : '0;
    assign link_reg     = cur_bank.hit ? bank_rd_link   : '0;

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R3
    vector_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (pc_load && pc_target == XLEN'({exc_code, 2'b00})));

    // R5
    norm_mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> status[BIT_I]);

    // R6
    saved_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> saved_status == $past(status));

    // R8
    state_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> !status[BIT_T]);

    // R9
    fast_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec[EXC_FIQ] || grant_vec[EXC_IRQ]) |->
            !(grant_vec[EXC_FIQ] ? status[BIT_F] : status[BIT_I]));

    // R11
    user_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4:0] == MODE_USR && sw_wr && !exc_go && !ret_strobe)
            |=> status[7:0] == $past(status[7:0]));

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_reset = 0, req_dabort = 0, req_fast = 0, req_norm = 0;
    logic req_pabort = 0, req_undef = 0, req_call = 0;
    logic [31:0] cur_pc = '0;
    logic ret_strobe = 0;
    logic [31:0] ret_addr = '0;
    logic sw_wr = 0;
    logic [31:0] sw_data = '0;
    logic [31:0] status, saved_status, link_reg, pc_target;
    logic pc_load, exc_taken;
    logic [2:0] exc_code;

    int n_chk = 0;
    int n_err = 0;
    string cur_req = "R1";
    bit done = 0;

    logic [31:0] m_status, m_pc_t;
    logic [31:0] m_spsr [0:4];
    logic [31:0] m_lr [0:4];
    bit m_pcl, m_taken;
    int m_code;

    always #5 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_dabort(req_dabort), .req_fast(req_fast),
        .req_norm(req_norm), .req_pabort(req_pabort), .req_undef(req_undef),
        .req_call(req_call), .cur_pc(cur_pc), .ret_strobe(ret_strobe),
        .ret_addr(ret_addr), .sw_wr(sw_wr), .sw_data(sw_data),
        .status(status), .saved_status(saved_status), .link_reg(link_reg),
        .pc_load(pc_load), .pc_target(pc_target), .exc_taken(exc_taken),
        .exc_code(exc_code)
    );

    function automatic int bidx(input logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            5'h1B: return 4;
            default: return -1;
        endcase
    endfunction

    // Behavioural reference model.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = 32'h0000_00D3;
            m_pc_t = 0; m_pcl = 0; m_taken = 0; m_code = 0;
            for (int i = 0; i < 5; i++) begin m_spsr[i] = 0; m_lr[i] = 0; end
        end else begin
            int c;
            c = -1;
            if (req_reset) c = 0;
            else if (req_dabort) c = 4;
            else if (req_fast && !m_status[6]) c = 7;
            else if (req_norm && !m_status[7]) c = 6;
            else if (req_pabort) c = 3;
            else if (req_undef) c = 1;
            else if (req_call) c = 2;
            m_pcl = 0;
            m_taken = 0;
            if (c >= 0) begin
                logic [4:0] md;
                int b;
                case (c)
                    7: md = 5'h11;
                    6: md = 5'h12;
                    1: md = 5'h1B;
                    3, 4: md = 5'h17;
                    default: md = 5'h13;
                endcase
                b = bidx(md);
                m_spsr[b] = m_status;
                m_lr[b] = cur_pc + (m_status[5] ? 32'd2 : 32'd4);
                m_status[4:0] = md;
                m_status[7] = 1'b1;
                if (c == 0 || c == 7) m_status[6] = 1'b1;
                m_status[5] = 1'b0;
                m_pc_t = c * 4;
                m_pcl = 1; m_taken = 1; m_code = c;
            end else if (ret_strobe && bidx(m_status[4:0]) >= 0) begin
                m_status = m_spsr[bidx(m_status[4:0])];
                m_pc_t = ret_addr;
                m_pcl = 1;
            end else if (sw_wr) begin
                bit user;
                user = (m_status[4:0] == 5'h10);
                m_status[31:28] = sw_data[31:28];
                if (!user) m_status[7:0] = sw_data[7:0];
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        int b;
        b = bidx(m_status[4:0]);
        check(cur_req, "status", status, m_status);
        check(cur_req, "saved_status", saved_status, b >= 0 ? m_spsr[b] : 32'h0);
        check(cur_req, "link_reg", link_reg, b >= 0 ? m_lr[b] : 32'h0);
        check(cur_req, "pc_load", {31'h0, pc_load}, {31'h0, m_pcl});
        check(cur_req, "pc_target", pc_target, m_pc_t);
        check(cur_req, "exc_taken", {31'h0, exc_taken}, {31'h0, m_taken});
        check(cur_req, "exc_code", {29'h0, exc_code}, 32'(m_code));
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare_model();
    endtask

    task automatic clear_in();
        req_reset = 0; req_dabort = 0; req_fast = 0; req_norm = 0;
        req_pabort = 0; req_undef = 0; req_call = 0;
        ret_strobe = 0; sw_wr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "status", status, 32'h0000_00D3);
        check("R1", "pc_load", {31'h0, pc_load}, 32'h0);
        check("R1", "exc_taken", {31'h0, exc_taken}, 32'h0);
        check("R1", "saved_status", saved_status, 32'h0);

        // R11 privileged write: flags and control byte
        cur_req = "R11";
        sw_wr = 1; sw_data = 32'hA000_0013; tick(); clear_in();
        check("R11", "priv write", status, 32'hA000_0013);
        sw_wr = 1; sw_data = 32'hA000_0030; tick(); clear_in();
        sw_wr = 1; sw_data = 32'h5000_00D3; tick(); clear_in();
        check("R11", "user write ctl ignored", status, 32'h5000_0030);

        // R4 R5 R7 R8 software call from compact state
        cur_req = "R7";
        req_call = 1; cur_pc = 32'h1000; tick(); clear_in();
        check("R4", "call mode", status, 32'h5000_0093);
        check("R7", "compact link", link_reg, 32'h0000_1002);
        check("R6", "saved", saved_status, 32'h5000_0030);
        check("R3", "call vector", pc_target, 32'h8);
        check("R12", "taken", {31'h0, exc_taken}, 32'h1);
        cur_req = "R12";
        tick();
        check("R12", "taken drops", {31'h0, exc_taken}, 32'h0);
        check("R12", "code held", {29'h0, exc_code}, 32'h2);

        // R9 normal request masked
        cur_req = "R9";
        req_norm = 1; tick(); clear_in();
        check("R9", "masked irq", {31'h0, exc_taken}, 32'h0);

        // R2 fast beats normal
        cur_req = "R2";
        sw_wr = 1; sw_data = 32'h5000_0013; tick(); clear_in();
        req_norm = 1; req_fast = 1; cur_pc = 32'h2000; tick();
        req_fast = 0;
        check("R2", "fast wins code", {29'h0, exc_code}, 32'h7);
        check("R5", "fast masks", status, 32'h5000_00D1);
        check("R3", "fast vector", pc_target, 32'h1C);
        check("R7", "link", link_reg, 32'h2004);
        cur_req = "R9";
        tick();
        check("R9", "irq blocked in fast", {31'h0, exc_taken}, 32'h0);
        // R10 return with normal request held
        cur_req = "R10";
        ret_strobe = 1; ret_addr = 32'h2000; tick(); ret_strobe = 0;
        check("R10", "restored", status, 32'h5000_0013);
        check("R10", "ret target", pc_target, 32'h2000);
        cur_req = "R2";
        cur_pc = 32'h3000; tick(); clear_in();
        check("R4", "irq mode", status, 32'h5000_0092);
        req_fast = 1; cur_pc = 32'h3100; tick(); clear_in();
        check("R2", "fast preempts irq", status, 32'h5000_00D1);
        check("R6", "irq status saved", saved_status, 32'h5000_0092);
        cur_req = "R10";
        ret_strobe = 1; ret_addr = 32'h3100; tick(); clear_in();
        check("R10", "back in irq", status, 32'h5000_0092);
        check("R10", "irq link", link_reg, 32'h3004);
        ret_strobe = 1; ret_addr = 32'h3004; tick(); clear_in();
        check("R10", "back in svc", status, 32'h5000_0013);
        ret_strobe = 1; ret_addr = 32'h1002; tick(); clear_in();
        check("R10", "back in user", status, 32'h5000_0030);
        ret_strobe = 1; ret_addr = 32'h7777; tick(); clear_in();
        check("R10", "user return ignored", {31'h0, pc_load}, 32'h0);
        check("R10", "user return status", status, 32'h5000_0030);

        // R2 full arbitration ladder
        cur_req = "R2";
        req_reset = 1; req_dabort = 1; req_fast = 1; req_norm = 1;
        req_pabort = 1; req_undef = 1; req_call = 1; cur_pc = 32'h4000;
        tick(); clear_in();
        check("R2", "reset first", status, 32'h5000_00D3);
        check("R3", "reset vector", pc_target, 32'h0);
        req_dabort = 1; req_pabort = 1; req_undef = 1; req_call = 1;
        cur_pc = 32'h4100; tick(); clear_in();
        check("R2", "dabort code", {29'h0, exc_code}, 32'h4);
        check("R5", "F kept", status, 32'h5000_00D7);
        req_pabort = 1; req_undef = 1; cur_pc = 32'h4200; tick(); clear_in();
        check("R2", "pabort code", {29'h0, exc_code}, 32'h3);
        req_undef = 1; req_call = 1; tick(); clear_in();
        check("R2", "undef code", {29'h0, exc_code}, 32'h1);
        check("R4", "undef mode", status, 32'h5000_00DB);

        // R10 R11 collisions with an entry
        cur_req = "R10";
        req_call = 1; ret_strobe = 1; ret_addr = 32'h9999;
        sw_wr = 1; sw_data = 32'h0000_001F; tick(); clear_in();
        check("R10", "entry beats return", pc_target, 32'h8);
        check("R11", "entry beats write", status, 32'h5000_00D3);

        // Random phase against the model
        cur_req = "R6";
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] modes [7];
            modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
            req_reset  = ($urandom % 97) == 0;
            req_dabort = ($urandom % 23) == 0;
            req_fast   = ($urandom % 9) == 0;
            req_norm   = ($urandom % 5) == 0;
            req_pabort = ($urandom % 19) == 0;
            req_undef  = ($urandom % 17) == 0;
            req_call   = ($urandom % 13) == 0;
            ret_strobe = ($urandom % 4) == 0;
            ret_addr   = $urandom;
            sw_wr      = ($urandom % 4) == 0;
            sw_data    = $urandom;
            sw_data[4:0] = modes[$urandom % 7];
            cur_pc     = $urandom & 32'hFFFF_FFFE;
            tick();
        end
        clear_in();
        finish_run();
    end

endmodule